// File: doc/BRIEF.md
# Rule-Vote Category Classifier

This block turns the raw outputs of a large array of binary functional units into a single category decision. The units are grouped by category. Each category owns M rule rows, and each rule row owns N units. A rule row votes for its category only when every one of its N units reports 1. The block counts the votes of each category and picks the category with the most votes. It then reports the index of that category, its vote count and a scaled certainty figure. The units themselves, and the way they are programmed, sit outside this block.

An upstream source offers one complete unit vector per evaluation on a valid/ready input. The vector is sampled only in the cycle where `in_valid` and `in_ready` are both high. A source that sees `in_ready` low must keep `in_valid` and the vector steady until `in_ready` rises again. The block computes all K vote counts in the accepting cycle and registers them. It then compares the counts one category per clock. One cycle after the last comparison it pulses `done`, and in that same cycle it updates the result outputs. The block is free to accept the next vector in that same cycle.

Top module: `rule_vote_classifier`

## Requirements
- R1: Unit u of row r of category k sits at bit (k*M + r)*N + u of `in_units`. A row is active only when all N of its bits are 1. A row with any 0 bit casts no vote.
- R2: The vote count of a category is the number of its active rows. It lies in the range 0 to M.
- R3: `win_idx` names the category with the largest vote count. When several categories share that count, the lowest index among them wins.
- R4: `win_count` equals the vote count of the category named by `win_idx`.
- R5: `done` is high for exactly one cycle. It rises after the (K+1)th rising edge that follows the edge that accepted the vector.
- R6: `in_ready` falls on the edge after an acceptance and stays low until the cycle in which `done` is high. While it is low, the vector and `in_valid` are ignored. A held request is taken on the first edge at which `in_ready` is high.
- R7: `win_idx`, `win_count` and `win_certainty` change only in a cycle in which `done` is high. They hold their values between pulses.
- R8: `win_certainty` equals floor(`win_count` * (2^CERT_W - 1) / M). A full vote count of M therefore reads as all ones.
- R9: While `rst_n` is low, and after it is released, the block is idle: `in_ready` is 1, `done` is 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A unit vector is offered |
| in_ready | output | 1 | The block can take a vector |
| in_units | input | K*M*N | Unit output bits, grouped by category, then row, then unit |
| done | output | 1 | One-cycle pulse marking new results |
| win_idx | output | max(1,clog2(K)) | Winning category |
| win_count | output | clog2(M+1) | Vote count of the winner |
| win_certainty | output | CERT_W | Winner's count scaled to the range 0 to full scale |

## Verification
The winner assertions compare the result outputs against the registered vote counts in the `done` cycle. They assume that those counts do not move between acceptance and `done`, which holds only because `in_ready` stays low during the scan and the source obeys the handshake. The bench drives inputs only on falling edges. It keeps `in_valid` and the vector steady until it has seen `in_ready` high, and it changes the vector freely only while `in_valid` is low or the block is busy. The stimulus therefore never asks the block to take two vectors inside one scan.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_SCAN   = 2'd1,
    SC_FINISH = 2'd2
  } scan_state_e;

  function automatic int cnt_width(input int rows);
    return $clog2(rows + 1);
  endfunction

  function automatic int idx_width(input int cats);
    return (cats > 1) ? $clog2(cats) : 1;
  endfunction

endpackage

// File: rtl/rvc_rule_rows.sv
module rvc_rule_rows #(
  parameter int M = 8,
  parameter int N = 6
) (
  input  logic [M*N-1:0] units,
  output logic [M-1:0]   row_hit
);
  for (genvar r = 0; r < M; r++) begin : g_row
    assign row_hit[r] = &units[r*N +: N];
  end
endmodule

// File: rtl/rvc_vote_count.sv
module rvc_vote_count #(
  parameter int M  = 8,
  parameter int CW = rvc_pkg::cnt_width(M)
) (
  input  logic [M-1:0]  row_hit,
  output logic [CW-1:0] votes
);
  always_comb begin
    votes = '0;
    for (int r = 0; r < M; r++) begin
      votes = votes + CW'(row_hit[r]);
    end
  end
endmodule

// File: rtl/rvc_certainty.sv
module rvc_certainty #(
  parameter int M      = 8,
  parameter int CW     = rvc_pkg::cnt_width(M),
  parameter int CERT_W = 8
) (
  input  logic [CW-1:0]     count,
  output logic [CERT_W-1:0] certainty
);
  localparam int PW = CW + CERT_W;
  localparam logic [PW-1:0] FULL = PW'((2 ** CERT_W) - 1);
  localparam logic [PW-1:0] DIV  = PW'(M);

  logic [PW-1:0] prod;
  logic [PW-1:0] quot;

  always_comb begin
    prod      = PW'(count) * FULL;
    quot      = prod / DIV;
    certainty = quot[CERT_W-1:0];
  end
endmodule

// File: rtl/rvc_max_scan.sv
module rvc_max_scan
  import rvc_pkg::*;
#(
  parameter int K  = 4,
  parameter int M  = 8,
  parameter int CW = cnt_width(M),
  parameter int IW = idx_width(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] counts [K],
  output logic          ready,
  output logic          done,
  output logic [IW-1:0] win_idx,
  output logic [CW-1:0] win_count
);
  localparam logic [IW-1:0] LAST = IW'(K - 1);

  scan_state_e   state_q;
  logic [IW-1:0] scan_idx_q;
  logic [IW-1:0] best_idx_q;
  logic [CW-1:0] best_cnt_q;
  logic [CW-1:0] cur_cnt;
  logic          take_cur;

  always_comb begin
    cur_cnt  = counts[scan_idx_q];
    take_cur = (scan_idx_q == '0) || (cur_cnt > best_cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SC_IDLE;
      scan_idx_q <= '0;
      best_idx_q <= '0;
      best_cnt_q <= '0;
      win_idx    <= '0;
      win_count  <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        SC_IDLE: begin
          if (start) begin
            state_q    <= SC_SCAN;
            scan_idx_q <= '0;
          end
        end
        SC_SCAN: begin
          if (take_cur) begin
            best_cnt_q <= cur_cnt;
            best_idx_q <= scan_idx_q;
          end
          if (scan_idx_q == LAST) begin
            state_q <= SC_FINISH;
          end else begin
            scan_idx_q <= scan_idx_q + 1'b1;
          end
        end
        SC_FINISH: begin
          win_idx   <= best_idx_q;
          win_count <= best_cnt_q;
          done      <= 1'b1;
          state_q   <= SC_IDLE;
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  assign ready = (state_q == SC_IDLE);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  assert_ready_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(win_idx) && $stable(win_count)));

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (win_idx <= LAST));

  assert_count_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (win_count == counts[win_idx]));

  for (genvar k = 0; k < K; k++) begin : g_chk
    assert_not_beaten_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (counts[k] <= win_count));
    assert_lowest_tie_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (IW'(k) < win_idx)) |-> (counts[k] < win_count));
  end
endmodule

// File: rtl/rule_vote_classifier.sv
module rule_vote_classifier
  import rvc_pkg::*;
#(
  parameter int K      = 4,
  parameter int M      = 8,
  parameter int N      = 6,
  parameter int CERT_W = 8,
  localparam int CW    = cnt_width(M),
  localparam int IW    = idx_width(K),
  localparam int UW    = K * M * N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [UW-1:0]     in_units,
  output logic              done,
  output logic [IW-1:0]     win_idx,
  output logic [CW-1:0]     win_count,
  output logic [CERT_W-1:0] win_certainty
);
  localparam int CAT_W = M * N;

  logic          accept;
  logic [CW-1:0] votes_now [K];
  logic [CW-1:0] votes_q   [K];

  assign accept = in_valid && in_ready;

  for (genvar k = 0; k < K; k++) begin : g_cat
    logic [M-1:0] row_hit;

    rvc_rule_rows #(.M(M), .N(N)) u_rows (
      .units   (in_units[k*CAT_W +: CAT_W]),
      .row_hit (row_hit)
    );

    rvc_vote_count #(.M(M), .CW(CW)) u_count (
      .row_hit (row_hit),
      .votes   (votes_now[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        votes_q[k] <= '0;
      end else if (accept) begin
        votes_q[k] <= votes_now[k];
      end
    end

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      votes_q[k] <= CW'(M));
  end

  rvc_max_scan #(.K(K), .M(M), .CW(CW), .IW(IW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .counts    (votes_q),
    .ready     (in_ready),
    .done      (done),
    .win_idx   (win_idx),
    .win_count (win_count)
  );

  rvc_certainty #(.M(M), .CW(CW), .CERT_W(CERT_W)) u_cert (
    .count     (win_count),
    .certainty (win_certainty)
  );

  assert_cert_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_count == CW'(M)) |-> (win_certainty == {CERT_W{1'b1}}));

  assert_cert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_count == '0) |-> (win_certainty == '0));
endmodule

// File: tb/rule_vote_classifier_tb_top.sv
module rule_vote_classifier_tb_top;
  localparam int K = 3;
  localparam int M = 4;
  localparam int N = 2;
  localparam int CERT_W = 8;
  localparam int UW = K * M * N;
  localparam int NV = 8;

  // {units {cat2,cat1,cat0}, expected index, expected count}
  localparam logic [28:0] TBL [NV] = '{
    {24'h0F00FF, 2'd0, 3'd4},
    {24'h3F0F03, 2'd2, 3'd3},
    {24'h00AA55, 2'd0, 3'd0},
    {24'h3CF00F, 2'd0, 3'd2},
    {24'h323301, 2'd1, 3'd2},
    {24'hFFFF7F, 2'd1, 3'd4},
    {24'hC00000, 2'd2, 3'd1},
    {24'hFECFBF, 2'd0, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [UW-1:0] in_units = '0;
  logic done;
  logic [1:0] win_idx;
  logic [2:0] win_count;
  logic [CERT_W-1:0] win_certainty;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rule_vote_classifier #(.K(K), .M(M), .N(N), .CERT_W(CERT_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_units      (in_units),
    .done          (done),
    .win_idx       (win_idx),
    .win_count     (win_count),
    .win_certainty (win_certainty)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int cert_of(input int c);
    return (c * ((1 << CERT_W) - 1)) / M;
  endfunction

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done && lat < 40);
  endtask

  task automatic check_result(input string tag, input int idx, input int cnt);
    chk({tag, " R3 winner index"}, win_idx, idx);
    chk({tag, " R2 R4 winner count"}, win_count, cnt);
    chk({tag, " R8 certainty"}, win_certainty, cert_of(cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [2:0] h_cnt;
    logic [1:0] h_idx;

    repeat (3) @(negedge clk);
    chk("R9 ready in reset", in_ready, 1);
    chk("R9 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", in_ready, 1);
    chk("R9 done after reset", done, 0);
    chk("R9 index after reset", win_idx, 0);
    chk("R9 count after reset", win_count, 0);
    chk("R9 certainty after reset", win_certainty, 0);

    // table walk: R1 partial rows, R3 ties, R5 latency, R6 busy
    for (int i = 0; i < NV; i++) begin
      in_units = TBL[i][28:5];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 ready low after accept", in_ready, 0);
      wait_done(lat);
      chk("R5 latency to done", lat, K + 1);
      check_result($sformatf("R1 vec%0d", i), TBL[i][4:3], TBL[i][2:0]);
      @(negedge clk);
      chk("R5 done single cycle", done, 0);
    end

    // R7: outputs hold while new inputs move without a request
    h_idx = win_idx;
    h_cnt = win_count;
    for (int c = 0; c < 6; c++) begin
      in_units = {UW{1'b1}} ^ UW'(c * 7);
      @(negedge clk);
      chk("R7 index held", win_idx, h_idx);
      chk("R7 count held", win_count, h_cnt);
      chk("R7 no spurious done", done, 0);
    end

    // R6 back-pressure: request held across a busy scan
    @(negedge clk);
    in_units = TBL[1][28:5];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_units = TBL[5][28:5];
    chk("R6 busy after accept", in_ready, 0);
    wait_done(lat);
    chk("R6 held vector ignored while busy", win_idx, 2);
    chk("R6 ready with done", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 done dropped", done, 0);
    chk("R6 held request taken", in_ready, 0);
    wait_done(lat);
    chk("R5 latency second vector", lat, K + 1);
    check_result("R6 second", 1, 4);

    // R1: every row missing one unit bit gives no votes anywhere
    @(negedge clk);
    in_units = {(UW/2){2'b10}};
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_done(lat);
    check_result("R1 no full rows", 0, 0);

    // R9: reset in mid scan returns the block to idle
    @(negedge clk);
    in_units = TBL[0][28:5];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after mid-scan reset", in_ready, 1);
    chk("R9 count cleared", win_count, 0);
    repeat (K + 2) begin
      @(negedge clk);
      chk("R9 no done after reset", done, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule